// File: doc/BRIEF.md
# Sampling Record Address Selector

This block sits beside a processor core's sampling logic. It decides whether a precise sampling record is emitted when an instruction retires or a protected-region exit event completes, and which address that record reports as the eventing address. A separate overflow strobe marks a sample as pending. The block holds that sample until a qualifying event consumes it. Writing the record to memory is handled elsewhere.

The reported address depends on how the protected region was entered. An opt-in entry reports the event's own address. An opt-out entry hides the inner addresses: records at exit then report the address of the most recent enter or resume instruction. The block keeps that address in a register. Outputs are registered, so a record appears one cycle after the event that produced it.

Leaf-type codes (4 bits): 1 = privileged leaf, 2 = key derivation, 3 = report, 4 = enter, 5 = resume, 6 = normal exit. Every other code is an ordinary instruction. The input `opt_out_i` is 1 for opt-out mode and 0 for opt-in mode.

Top module: `sampsel_top`

## Requirements
- R1: After a synchronous reset, `rec_vld_o` is 0, `rec_addr_o` is 0, no sample is pending and the stored last-entry address is 0.
- R2: A retirement with code 1, 2 or 3 while a sample is pending produces a record one cycle later, carrying `insn_addr_i`.
- R3: A retirement with code 4 or 5 while a sample is pending produces a record carrying `insn_addr_i` in opt-in mode. In opt-out mode it produces no record, and the sample stays pending.
- R4: A retirement with code 6 while a sample is pending produces a record. The record carries `insn_addr_i` in opt-in mode and the stored last-entry address in opt-out mode.
- R5: `aex_i` while a sample is pending produces a record. The record carries `ssa_addr_i` in opt-in mode and the stored last-entry address in opt-out mode.
- R6: `deliv_done_i` while a sample is pending produces a record carrying `aep_addr_i`.
- R7: Every retirement with code 4 or 5 loads `insn_addr_i` into the last-entry register. This happens in either mode, whether or not a sample is pending.
- R8: `smp_pend_i` makes a sample pending, and it stays pending until a record is issued. Issuing a record clears it. A pulse on `smp_pend_i` in the same cycle as a qualifying event is consumed by that record.
- R9: A retirement with code 0 or 7 to 15 produces no record and leaves a pending sample untouched.
- R10: At most one record is issued per cycle. The priority is `aex_i`, then `deliv_done_i`, then retirement. Lower-priority events in the same cycle produce no record.
- R11: With no sample pending and no `smp_pend_i` pulse, no event produces a record. Each record lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | An instruction retires this cycle |
| leaf_i | input | 4 | Leaf-type code of the retiring instruction |
| insn_addr_i | input | AW | Linear address of the retiring instruction |
| opt_out_i | input | 1 | Current entry mode: 1 = opt-out, 0 = opt-in |
| aex_i | input | 1 | Asynchronous exit completes this cycle |
| ssa_addr_i | input | AW | Address saved in the state save area by the asynchronous exit |
| aep_addr_i | input | AW | Exit-handler address |
| deliv_done_i | input | 1 | Delivery of the exit event completes this cycle |
| smp_pend_i | input | 1 | Counter overflow: mark a sample pending |
| rec_vld_o | output | 1 | Record strobe (registered) |
| rec_addr_o | output | AW | Eventing address of the record (registered) |

## Verification
The bound checker checks these properties on every cycle:
- the reset state;
- that nothing fires without a pending sample;
- that a record always clears the pending flag;
- the address carried by a record after an asynchronous exit (in both modes) and after an exit-event delivery;
- the last-entry load;
- the silence of unlisted codes.

Some behaviours are sequences that only the bench's scenarios can show:
- a sample that survives an opt-out enter and is consumed later;
- an opt-out exit that reports an enter address loaded many cycles earlier;
- the ordering when three events coincide.

Long pseudo-random runs are compared against the bench's behavioural model on every clock.

// File: rtl/sampsel_pkg.sv
package sampsel_pkg;

  localparam int LEAF_W    = 4;
  localparam int NUM_KINDS = 7;

  typedef enum logic [LEAF_W-1:0] {
    LF_NONE   = 4'd0,
    LF_PRIV   = 4'd1,
    LF_KEYDER = 4'd2,
    LF_REPORT = 4'd3,
    LF_ENTER  = 4'd4,
    LF_RESUME = 4'd5,
    LF_EXIT   = 4'd6
  } leaf_e;

  typedef enum logic [1:0] {
    SRC_OWN  = 2'd0,
    SRC_LAST = 2'd1,
    SRC_SSA  = 2'd2,
    SRC_AEP  = 2'd3
  } addr_src_e;

  typedef struct packed {
    logic      cand;
    logic      is_entry;
    addr_src_e src;
  } leaf_dec_t;

endpackage

// File: rtl/sampsel_classify.sv
module sampsel_classify
  import sampsel_pkg::*;
(
  input  logic              retire_i,
  input  logic [LEAF_W-1:0] leaf_i,
  input  logic              opt_out_i,
  output leaf_dec_t         dec_o
);

  logic [NUM_KINDS-1:1] hot;

  for (genvar g = 1; g < NUM_KINDS; g++) begin : g_hot
    assign hot[g] = (leaf_i == LEAF_W'(g));
  end

  logic own_rep;
  logic entry;

  assign own_rep = hot[int'(LF_PRIV)] | hot[int'(LF_KEYDER)] | hot[int'(LF_REPORT)];
  assign entry   = hot[int'(LF_ENTER)] | hot[int'(LF_RESUME)];

  always_comb begin
    dec_o = '{cand: 1'b0, is_entry: 1'b0, src: SRC_OWN};
    if (retire_i) begin
      if (own_rep) begin
        dec_o.cand = 1'b1;
      end else if (entry) begin
        dec_o.is_entry = 1'b1;
        dec_o.cand     = ~opt_out_i;
      end else if (hot[int'(LF_EXIT)]) begin
        dec_o.cand = 1'b1;
        dec_o.src  = opt_out_i ? SRC_LAST : SRC_OWN;
      end
    end
  end

endmodule

// File: rtl/sampsel_entry_reg.sv
module sampsel_entry_reg #(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] last_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_o <= '0;
    end else if (ld_i) begin
      last_o <= addr_i;
    end
  end

endmodule

// File: rtl/sampsel_pend.sv
module sampsel_pend (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic take_i,
  output logic pend_q_o,
  output logic pend_eff_o
);

  assign pend_eff_o = pend_q_o | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q_o <= 1'b0;
    end else if (take_i) begin
      pend_q_o <= 1'b0;
    end else begin
      pend_q_o <= pend_eff_o;
    end
  end

endmodule

// File: rtl/sampsel_arb.sv
module sampsel_arb
  import sampsel_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          aex_i,
  input  logic          deliv_i,
  input  logic          cand_i,
  input  addr_src_e     src_i,
  input  logic          pend_eff_i,
  input  logic          opt_out_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic [AW-1:0] ssa_addr_i,
  input  logic [AW-1:0] aep_addr_i,
  input  logic [AW-1:0] last_addr_i,
  output logic          take_o,
  output logic          rec_vld_o,
  output logic [AW-1:0] rec_addr_o
);

  addr_src_e     sel;
  logic [AW-1:0] pick;

  always_comb begin
    if (aex_i) begin
      take_o = pend_eff_i;
      sel    = opt_out_i ? SRC_LAST : SRC_SSA;
    end else if (deliv_i) begin
      take_o = pend_eff_i;
      sel    = SRC_AEP;
    end else begin
      take_o = pend_eff_i & cand_i;
      sel    = src_i;
    end
  end

  always_comb begin
    unique case (sel)
      SRC_OWN:  pick = own_addr_i;
      SRC_LAST: pick = last_addr_i;
      SRC_SSA:  pick = ssa_addr_i;
      default:  pick = aep_addr_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_vld_o  <= 1'b0;
      rec_addr_o <= '0;
    end else begin
      rec_vld_o <= take_o;
      if (take_o) begin
        rec_addr_o <= pick;
      end
    end
  end

endmodule

// File: rtl/sampsel_top.sv
module sampsel_top
  import sampsel_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_i,
  input  logic [LEAF_W-1:0] leaf_i,
  input  logic [AW-1:0]     insn_addr_i,
  input  logic              opt_out_i,
  input  logic              aex_i,
  input  logic [AW-1:0]     ssa_addr_i,
  input  logic [AW-1:0]     aep_addr_i,
  input  logic              deliv_done_i,
  input  logic              smp_pend_i,
  output logic              rec_vld_o,
  output logic [AW-1:0]     rec_addr_o
);

  leaf_dec_t     dec;
  logic          pend_q;
  logic          pend_eff;
  logic          take;
  logic [AW-1:0] last_q;

  sampsel_classify u_cls (
    .retire_i  (retire_i),
    .leaf_i    (leaf_i),
    .opt_out_i (opt_out_i),
    .dec_o     (dec)
  );

  sampsel_entry_reg #(.AW(AW)) u_last (
    .clk    (clk),
    .rst    (rst),
    .ld_i   (dec.is_entry),
    .addr_i (insn_addr_i),
    .last_o (last_q)
  );

  sampsel_pend u_pend (
    .clk        (clk),
    .rst        (rst),
    .set_i      (smp_pend_i),
    .take_i     (take),
    .pend_q_o   (pend_q),
    .pend_eff_o (pend_eff)
  );

  sampsel_arb #(.AW(AW)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .aex_i       (aex_i),
    .deliv_i     (deliv_done_i),
    .cand_i      (dec.cand),
    .src_i       (dec.src),
    .pend_eff_i  (pend_eff),
    .opt_out_i   (opt_out_i),
    .own_addr_i  (insn_addr_i),
    .ssa_addr_i  (ssa_addr_i),
    .aep_addr_i  (aep_addr_i),
    .last_addr_i (last_q),
    .take_o      (take),
    .rec_vld_o   (rec_vld_o),
    .rec_addr_o  (rec_addr_o)
  );

endmodule

// File: rtl/sampsel_chk.sv
module sampsel_chk #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          retire_i,
  input logic [3:0]    leaf_i,
  input logic [AW-1:0] insn_addr_i,
  input logic          opt_out_i,
  input logic          aex_i,
  input logic [AW-1:0] ssa_addr_i,
  input logic [AW-1:0] aep_addr_i,
  input logic          deliv_done_i,
  input logic          smp_pend_i,
  input logic          rec_vld_o,
  input logic [AW-1:0] rec_addr_o,
  input logic          pend_q,
  input logic [AW-1:0] last_q
);

  logic pend_any;
  logic leaf_unlisted;
  logic leaf_entry;

  assign pend_any      = pend_q | smp_pend_i;
  assign leaf_unlisted = (leaf_i == 4'd0) || (leaf_i > 4'd6);
  assign leaf_entry    = (leaf_i == 4'd4) || (leaf_i == 4'd5);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rec_vld_o && rec_addr_o == '0 && !pend_q && last_q == '0));

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_any |=> !rec_vld_o);

  // R8
  clear_on_rec_chk: assert property (@(posedge clk) disable iff (rst)
    rec_vld_o |-> !pend_q);

  // R5
  aex_optin_chk: assert property (@(posedge clk) disable iff (rst)
    (aex_i && pend_any && !opt_out_i) |=> (rec_vld_o && rec_addr_o == $past(ssa_addr_i)));

  // R5
  aex_optout_chk: assert property (@(posedge clk) disable iff (rst)
    (aex_i && pend_any && opt_out_i) |=> (rec_vld_o && rec_addr_o == $past(last_q)));

  // R6
  deliv_aep_chk: assert property (@(posedge clk) disable iff (rst)
    (deliv_done_i && !aex_i && pend_any) |=> (rec_vld_o && rec_addr_o == $past(aep_addr_i)));

  // R7
  entry_load_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && leaf_entry) |=> (last_q == $past(insn_addr_i)));

  // R9
  unlisted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && leaf_unlisted && !aex_i && !deliv_done_i) |=> (!rec_vld_o && pend_q == $past(pend_any)));

endmodule

bind sampsel_top sampsel_chk #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .retire_i     (retire_i),
  .leaf_i       (leaf_i),
  .insn_addr_i  (insn_addr_i),
  .opt_out_i    (opt_out_i),
  .aex_i        (aex_i),
  .ssa_addr_i   (ssa_addr_i),
  .aep_addr_i   (aep_addr_i),
  .deliv_done_i (deliv_done_i),
  .smp_pend_i   (smp_pend_i),
  .rec_vld_o    (rec_vld_o),
  .rec_addr_o   (rec_addr_o),
  .pend_q       (pend_q),
  .last_q       (last_q)
);

// File: tb/sampsel_top_tb_top.sv
module sampsel_top_tb_top;

  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst;
  logic          retire_i;
  logic [3:0]    leaf_i;
  logic [AW-1:0] insn_addr_i;
  logic          opt_out_i;
  logic          aex_i;
  logic [AW-1:0] ssa_addr_i;
  logic [AW-1:0] aep_addr_i;
  logic          deliv_done_i;
  logic          smp_pend_i;
  logic          rec_vld_o;
  logic [AW-1:0] rec_addr_o;

  always #5 clk = ~clk;

  sampsel_top #(.AW(AW)) dut_i (.*);

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  bit            m_pend;
  logic [AW-1:0] m_last;
  bit            e_vld;
  logic [AW-1:0] e_addr;

  task automatic clear_in();
    retire_i = 0; leaf_i = 0; insn_addr_i = '0; opt_out_i = 0;
    aex_i = 0; ssa_addr_i = '0; aep_addr_i = '0; deliv_done_i = 0; smp_pend_i = 0;
  endtask

  // behavioural reference for one clock edge
  task automatic model();
    bit            pe;
    bit            fire;
    logic [AW-1:0] ea;
    pe = m_pend | smp_pend_i;
    fire = 0;
    ea = '0;
    if (aex_i) begin
      fire = pe; ea = opt_out_i ? m_last : ssa_addr_i;
    end else if (deliv_done_i) begin
      fire = pe; ea = aep_addr_i;
    end else if (retire_i) begin
      case (leaf_i)
        4'd1, 4'd2, 4'd3: begin fire = pe; ea = insn_addr_i; end
        4'd4, 4'd5:       begin fire = pe && !opt_out_i; ea = insn_addr_i; end
        4'd6:             begin fire = pe; ea = opt_out_i ? m_last : insn_addr_i; end
        default:          fire = 0;
      endcase
    end
    m_pend = fire ? 1'b0 : pe;
    if (retire_i && (leaf_i == 4'd4 || leaf_i == 4'd5)) m_last = insn_addr_i;
    e_vld = fire;
    if (fire) e_addr = ea;
  endtask

  task automatic tick(input string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (rec_vld_o !== e_vld || (e_vld && rec_addr_o !== e_addr)) begin
      fails++;
      $display("FAIL %s: actual vld=%0b addr=%h expected vld=%0b addr=%h",
               tag, rec_vld_o, rec_addr_o, e_vld, e_addr);
    end
    clear_in();
  endtask

  task automatic ret(input logic [3:0] lf, input logic [AW-1:0] a, input bit oo, input bit ps);
    retire_i = 1; leaf_i = lf; insn_addr_i = a; opt_out_i = oo; smp_pend_i = ps;
  endtask

  initial begin
    clear_in();
    rst = 1;
    m_pend = 0; m_last = '0; e_vld = 0; e_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    vectors++;
    if (rec_vld_o !== 1'b0 || rec_addr_o !== '0) begin
      fails++;
      $display("FAIL R1: actual vld=%0b addr=%h expected vld=0 addr=0", rec_vld_o, rec_addr_o);
    end

    tick("R1 idle");
    ret(4'd1, 48'h1000, 0, 0);            tick("R11 no pending");
    smp_pend_i = 1;                        tick("R8 set");
    ret(4'd1, 48'h1100, 0, 0);            tick("R2 privileged");
    ret(4'd2, 48'h1200, 0, 1);            tick("R8 same-cycle set");
    ret(4'd3, 48'h1300, 0, 0);            tick("R11 consumed");
    ret(4'd3, 48'h1310, 0, 1);            tick("R2 report");
    ret(4'd4, 48'h2000, 0, 1);            tick("R3 enter opt-in");
    ret(4'd5, 48'h2100, 1, 1);            tick("R3 resume opt-out silent");
    tick("R3 hold");
    ret(4'd1, 48'h2200, 0, 0);            tick("R3 pending kept");
    ret(4'd6, 48'h3000, 0, 1);            tick("R4 exit opt-in");
    ret(4'd4, 48'h3100, 1, 0);            tick("R7 enter opt-out no pending");
    ret(4'd0, 48'h3150, 1, 0);            tick("R9 code 0");
    ret(4'd6, 48'h3200, 1, 1);            tick("R4 exit opt-out");
    smp_pend_i = 1; aex_i = 1; ssa_addr_i = 48'h4000; tick("R5 aex opt-in");
    smp_pend_i = 1; aex_i = 1; opt_out_i = 1; ssa_addr_i = 48'h4100; tick("R5 aex opt-out");
    smp_pend_i = 1; deliv_done_i = 1; aep_addr_i = 48'h5000; tick("R6 handler");
    deliv_done_i = 1; aep_addr_i = 48'h5100; tick("R11 handler no pending");
    ret(4'd7, 48'h6000, 0, 1);            tick("R9 code 7");
    ret(4'd15, 48'h6100, 0, 0);           tick("R9 code 15");
    ret(4'd2, 48'h6200, 0, 0);            tick("R9 pending untouched");
    ret(4'd1, 48'h7000, 0, 1); aex_i = 1; deliv_done_i = 1;
    ssa_addr_i = 48'h7100; aep_addr_i = 48'h7200; tick("R10 three-way");
    ret(4'd1, 48'h7300, 0, 0);            tick("R10 dropped");
    ret(4'd1, 48'h7400, 0, 1); deliv_done_i = 1; aep_addr_i = 48'h7500; tick("R10 deliv over retire");

    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 2000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        retire_i     = lfsr[0] | lfsr[1];
        leaf_i       = lfsr[5:2];
        insn_addr_i  = {32'h0, lfsr};
        opt_out_i    = lfsr[6];
        aex_i        = (lfsr[9:7] == 3'd0);
        ssa_addr_i   = {32'h1, lfsr};
        aep_addr_i   = {32'h2, lfsr};
        deliv_done_i = (lfsr[12:10] == 3'd1);
        smp_pend_i   = lfsr[13] & lfsr[14];
        tick("R10 random");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule